// File: doc/BRIEF.md
# Modulo Timer with Coherent Byte-Wise Reload

This block is an up-counting timer whose terminal count is held in a modulo register. Software writes that register over a narrow byte bus as two separate halves. Both halves go into a write buffer first, so the counter never compares against a value that is half old and half new. When the buffered value is copied into the modulo register depends on the clock-source select. If the counter is stopped, the copy happens on the write that completes the pair. If the counter is running, the copy waits until the counter steps onto the new terminal value.

When the counter passes its terminal value it wraps to zero and raises a sticky overflow flag. Overflow is suppressed while only one byte of a pair has been written. A debug-freeze input stops counting and holds the buffer bookkeeping. While freeze is asserted, byte writes go straight into the modulo register. A write to the counter's low-byte address clears the count. A write to the control address drops any half-finished byte pair.

Top module: `modtimer`

## Requirements
- R1: With a nonzero modulo value M, an advancing cycle taken at count M returns the count to zero and sets `tof`; counts below M step up by one.
- R2: After reset `count`, `modVal` and `tof` are zero. A modulo value of zero makes the counter run through its all-ones value and then wrap to zero, which also sets `tof`.
- R3: While exactly one byte of a pair has been written, a wrap does not set `tof`.
- R4: With `clkSel` equal to 2'b00, the counter does not advance. The write that completes a byte pair, in either byte order, updates `modVal` at that same clock edge.
- R5: With `clkSel` not equal to 2'b00, a completed pair leaves `modVal` unchanged until an advancing step takes the count from (new value − 1) to the new value. `modVal` changes on that step. A new value of zero loads on the step from all-ones minus one.
- R6: A `wrCtrl` pulse discards the half-written state. A byte written before the pulse does not pair with a byte written after it, and overflow suppression ends.
- R7: While `freeze` is high, `count` holds and the byte-pair state is kept. Each byte write lands directly in its half of `modVal` on the next edge.
- R8: A `wrCntLo` pulse makes `count` zero on the next edge, with priority over counting.
- R9: The count advances only on cycles where `cntEn` is high, `clkSel` is nonzero and `freeze` is low.
- R10: `tof` stays set until `tofClr` clears it. If a set and a clear fall in the same cycle, the set wins. `irq` equals `tof` AND `tofIe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 2 | Clock-source select; 2'b00 stops the counter |
| cntEn | input | 1 | Count-enable pulse |
| freeze | input | 1 | Debug freeze |
| wrData | input | BYTE_W | Write data byte |
| wrModHi | input | 1 | Write strobe for the modulo high byte |
| wrModLo | input | 1 | Write strobe for the modulo low byte |
| wrCntLo | input | 1 | Write strobe for the counter low byte (clears the counter) |
| wrCtrl | input | 1 | Write strobe for the control address (resets the pair latch) |
| tofClr | input | 1 | Clears the overflow flag |
| tofIe | input | 1 | Overflow interrupt enable |
| count | output | 2*BYTE_W | Counter value |
| modVal | output | 2*BYTE_W | Active modulo value |
| tof | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A corrupted pair-tracking bit can show up at the ports in two ways. Either `modVal` changes a byte too early, on a single write, or it never takes the completed pair. Either effect is visible one edge after the offending write. A stuck "half written" state shows up differently: a wrap M+1 advances later leaves `tof` low. A wrong load point shows in `modVal` on the exact step where the counter meets the new terminal. That makes a period one cycle too long or too short, which a per-cycle sweep of counts over many modulo values exposes within one period.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;
  // strobes issued by the control path to the datapath each cycle
  typedef struct packed {
    logic advance;   // counter steps this cycle
    logic wrap;      // counter returns to zero this cycle
    logic clearCnt;  // counter forced to zero
    logic capHi;     // high byte captured into buffer
    logic capLo;     // low byte captured into buffer
    logic directHi;  // high byte written straight to modulo (freeze)
    logic directLo;  // low byte written straight to modulo (freeze)
    logic loadMod;   // buffer copied into modulo register
    logic setTof;    // overflow flag set
  } strobes_t;
endpackage

// File: rtl/modtimer_ctrl.sv
module modtimer_ctrl
  import modtimer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkSel,
  input  logic       cntEn,
  input  logic       freeze,
  input  logic       wrModHi,
  input  logic       wrModLo,
  input  logic       wrCntLo,
  input  logic       wrCtrl,
  input  logic       atTerm,
  input  logic       atLoadPt,
  output strobes_t   stb
);
  logic hiSeen, loSeen;
  logic running, pairSoon;

  always_comb begin
    stb          = '0;
    running      = (clkSel != 2'b00);
    stb.advance  = cntEn && running && !freeze;
    stb.clearCnt = wrCntLo;
    stb.wrap     = stb.advance && atTerm && !wrCntLo;
    stb.capHi    = wrModHi && !freeze;
    stb.capLo    = wrModLo && !freeze;
    stb.directHi = wrModHi && freeze;
    stb.directLo = wrModLo && freeze;
    pairSoon     = (hiSeen || stb.capHi) && (loSeen || stb.capLo);
    if (!running)
      stb.loadMod = pairSoon && !freeze && !wrCtrl;
    else
      stb.loadMod = hiSeen && loSeen && !stb.capHi && !stb.capLo &&
                    stb.advance && !stb.wrap && !wrCntLo && atLoadPt && !wrCtrl;
    // half-written pair holds off the overflow flag
    stb.setTof   = stb.wrap && !(hiSeen ^ loSeen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSeen <= 1'b0;
      loSeen <= 1'b0;
    end else if (wrCtrl || stb.loadMod) begin
      hiSeen <= 1'b0;
      loSeen <= 1'b0;
    end else begin
      if (stb.capHi) hiSeen <= 1'b1;
      if (stb.capLo) loSeen <= 1'b1;
    end
  end
endmodule

// File: rtl/modtimer_dp.sv
module modtimer_dp
  import modtimer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic                  tofClr,
  input  strobes_t              stb,
  output logic [2*BYTE_W-1:0]   count,
  output logic [2*BYTE_W-1:0]   modVal,
  output logic                  tof,
  output logic                  atTerm,
  output logic                  atLoadPt
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int LANES = 2;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] pendVal, termVal, loadPt;
  logic [LANES-1:0] capB, dirB;

  assign capB = {stb.capHi, stb.capLo};
  assign dirB = {stb.directHi, stb.directLo};

  // one buffer byte and one modulo byte per lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] bufQ, modQ, loadB;
    assign loadB = capB[g] ? wrData : bufQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          bufQ <= '0;
      else if (capB[g])   bufQ <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            modQ <= '0;
      else if (stb.loadMod) modQ <= loadB;
      else if (dirB[g])     modQ <= wrData;
    end

    assign modVal[g*BYTE_W +: BYTE_W]  = modQ;
    assign pendVal[g*BYTE_W +: BYTE_W] = bufQ;
  end

  always_comb begin
    termVal  = (modVal == '0) ? ALL_ONES : modVal;
    loadPt   = (pendVal == '0) ? ALL_ONES - CNT_W'(1) : pendVal - CNT_W'(1);
    atTerm   = (count == termVal);
    atLoadPt = (count == loadPt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (stb.clearCnt) count <= '0;
    else if (stb.wrap)     count <= '0;
    else if (stb.advance)  count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tof <= 1'b0;
    else if (stb.setTof)  tof <= 1'b1;
    else if (tofClr)      tof <= 1'b0;
  end
endmodule

// File: rtl/modtimer.sv
module modtimer
  import modtimer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          clkSel,
  input  logic                cntEn,
  input  logic                freeze,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                wrModHi,
  input  logic                wrModLo,
  input  logic                wrCntLo,
  input  logic                wrCtrl,
  input  logic                tofClr,
  input  logic                tofIe,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] modVal,
  output logic                tof,
  output logic                irq
);
  strobes_t stb;
  logic atTerm, atLoadPt;

  modtimer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .cntEn(cntEn), .freeze(freeze),
    .wrModHi(wrModHi), .wrModLo(wrModLo), .wrCntLo(wrCntLo), .wrCtrl(wrCtrl),
    .atTerm(atTerm), .atLoadPt(atLoadPt), .stb(stb)
  );

  modtimer_dp #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .tofClr(tofClr), .stb(stb),
    .count(count), .modVal(modVal), .tof(tof),
    .atTerm(atTerm), .atLoadPt(atLoadPt)
  );

  assign irq = tof && tofIe;
endmodule

// File: rtl/modtimer_chk.sv
module modtimer_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          clkSel,
  input logic                cntEn,
  input logic                freeze,
  input logic                wrModHi,
  input logic                wrModLo,
  input logic                wrCntLo,
  input logic                tofClr,
  input logic                tofIe,
  input logic [2*BYTE_W-1:0] count,
  input logic [2*BYTE_W-1:0] modVal,
  input logic                tof,
  input logic                irq
);
  localparam int CNT_W = 2 * BYTE_W;
  logic stepping;
  logic [CNT_W-1:0] termSeen;
  assign stepping = cntEn && (clkSel != 2'b00) && !freeze;
  assign termSeen = (modVal == '0) ? {CNT_W{1'b1}} : modVal;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && !wrCntLo && count == termSeen) |=> (count == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !wrCntLo) |=> $stable(count));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrCntLo |=> (count == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stepping && !wrCntLo) |=> $stable(count));

  p_no_early_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((clkSel != 2'b00) && !cntEn && !wrModHi && !wrModLo) |=> $stable(modVal));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tof && !tofClr) |=> tof);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq == (tof && tofIe));
endmodule

bind modtimer modtimer_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .clkSel(clkSel), .cntEn(cntEn), .freeze(freeze),
  .wrModHi(wrModHi), .wrModLo(wrModLo), .wrCntLo(wrCntLo), .tofClr(tofClr),
  .tofIe(tofIe), .count(count), .modVal(modVal), .tof(tof), .irq(irq)
);

// File: tb/modtimer_tb_top.sv
module modtimer_tb_top;
  localparam int BW = 8;
  localparam int CW = 2 * BW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic cntEn = 1'b0, freeze = 1'b0;
  logic [BW-1:0] wrData = '0;
  logic wrModHi = 1'b0, wrModLo = 1'b0, wrCntLo = 1'b0, wrCtrl = 1'b0;
  logic tofClr = 1'b0, tofIe = 1'b0;
  logic [CW-1:0] count, modVal;
  logic tof, irq;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  modtimer #(.BYTE_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .cntEn(cntEn), .freeze(freeze),
    .wrData(wrData), .wrModHi(wrModHi), .wrModLo(wrModLo), .wrCntLo(wrCntLo),
    .wrCtrl(wrCtrl), .tofClr(tofClr), .tofIe(tofIe),
    .count(count), .modVal(modVal), .tof(tof), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrHi(input logic [BW-1:0] b);
    wrData = b; wrModHi = 1'b1; step(1); wrModHi = 1'b0;
  endtask
  task automatic wrLo(input logic [BW-1:0] b);
    wrData = b; wrModLo = 1'b1; step(1); wrModLo = 1'b0;
  endtask
  task automatic clrCnt();
    wrCntLo = 1'b1; step(1); wrCntLo = 1'b0;
  endtask
  task automatic clrTof();
    tofClr = 1'b1; step(1); tofClr = 1'b0;
  endtask
  task automatic setModStopped(input logic [CW-1:0] v);
    clkSel = 2'b00; cntEn = 1'b0;
    wrHi(v[CW-1:BW]); wrLo(v[BW-1:0]);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R2 reset state
    chk("R2 count reset", 32'(count), 0);
    chk("R2 mod reset", 32'(modVal), 0);
    chk("R2 tof reset", 32'(tof), 0);

    // R2 free run with modulo zero
    clkSel = 2'b01; cntEn = 1'b1;
    step(300);
    chk("R2 free count", 32'(count), 300);
    step(65535 - 300);
    chk("R2 free top", 32'(count), 32'hFFFF);
    chk("R2 no tof before wrap", 32'(tof), 0);
    step(1);
    chk("R2 free wrap", 32'(count), 0);
    chk("R2 free tof", 32'(tof), 1);
    cntEn = 1'b0;

    // R1/R4 sweep of modulo values, alternating byte order
    for (int m = 1; m <= 24; m++) begin
      clkSel = 2'b00;
      if (m % 2 == 0) begin wrHi(8'h00); wrLo(8'(m)); end
      else begin wrLo(8'(m)); wrHi(8'h00); end
      chk("R4 load on pair", 32'(modVal), 32'(m));
      clrCnt(); clrTof();
      chk("R8 count cleared", 32'(count), 0);
      clkSel = 2'(1 + (m % 3)); cntEn = 1'b1;
      for (int k = 1; k <= m; k++) begin
        step(1);
        chk("R1 count step", 32'(count), 32'(k));
        chk("R1 no early tof", 32'(tof), 0);
      end
      step(1);
      chk("R1 wrap zero", 32'(count), 0);
      chk("R1 wrap tof", 32'(tof), 1);
      cntEn = 1'b0;
    end

    // R9 enable gating
    setModStopped(16'h0000);
    clrCnt();
    clkSel = 2'b01;
    begin
      int expCnt = 0;
      for (int i = 0; i < 20; i++) begin
        cntEn = (i % 3 == 0);
        step(1);
        if (i % 3 == 0) expCnt++;
        chk("R9 gated count", 32'(count), 32'(expCnt));
      end
      clkSel = 2'b00; cntEn = 1'b1;
      step(5);
      chk("R4 stopped no count", 32'(count), 32'(expCnt));
      clkSel = 2'b01; freeze = 1'b1;
      step(5);
      chk("R7 freeze holds count", 32'(count), 32'(expCnt));
    end

    // R7 direct writes while frozen
    freeze = 1'b0; cntEn = 1'b0;
    setModStopped(16'h0030);
    clkSel = 2'b01; freeze = 1'b1;
    wrHi(8'h12);
    chk("R7 direct high", 32'(modVal), 32'h1230);
    freeze = 1'b0; clkSel = 2'b00;
    wrHi(8'h00);
    chk("R4 single byte no load", 32'(modVal), 32'h1230);
    freeze = 1'b1;
    wrLo(8'h77);
    chk("R7 direct low", 32'(modVal), 32'h1277);
    freeze = 1'b0;
    wrLo(8'h05);
    chk("R7 pair state kept", 32'(modVal), 32'h0005);

    // R5 running reload at new MOD-1 -> MOD
    setModStopped(16'd20);
    clrCnt(); clrTof();
    clkSel = 2'b01; cntEn = 1'b0;
    wrHi(8'h00);
    chk("R5 hold after high", 32'(modVal), 20);
    wrLo(8'd10);
    chk("R5 hold after pair", 32'(modVal), 20);
    cntEn = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      step(1);
      chk("R5 count", 32'(count), 32'(k));
      chk("R5 old mod kept", 32'(modVal), 20);
    end
    step(1);
    chk("R5 load step count", 32'(count), 10);
    chk("R5 load step mod", 32'(modVal), 10);
    step(1);
    chk("R5 wrap new mod", 32'(count), 0);
    chk("R5 tof", 32'(tof), 1);

    // R3 suppression with half-written pair, R6 release
    cntEn = 1'b0;
    clrCnt(); clrTof();
    wrHi(8'h00);
    cntEn = 1'b1;
    step(11);
    chk("R3 wrapped", 32'(count), 0);
    chk("R3 tof suppressed", 32'(tof), 0);
    cntEn = 1'b0;
    wrCtrl = 1'b1; step(1); wrCtrl = 1'b0;
    cntEn = 1'b1;
    step(11);
    chk("R6 tof after latch reset", 32'(tof), 1);
    cntEn = 1'b0;

    // R6 stopped mode: bytes across a latch reset do not pair
    clkSel = 2'b00;
    wrHi(8'h12);
    wrCtrl = 1'b1; step(1); wrCtrl = 1'b0;
    wrLo(8'h34);
    chk("R6 no pair across reset", 32'(modVal), 10);
    wrHi(8'h00);
    chk("R6 new pair", 32'(modVal), 32'h0034);

    // R8 counter clear while counting
    clrCnt();
    clkSel = 2'b01; cntEn = 1'b1;
    step(7);
    chk("R8 pre clear", 32'(count), 7);
    wrCntLo = 1'b1; step(1); wrCntLo = 1'b0;
    chk("R8 clear wins", 32'(count), 0);
    step(1);
    chk("R8 resumes", 32'(count), 1);

    // R10 flag behaviour
    cntEn = 1'b0;
    setModStopped(16'd3);
    clrCnt(); clrTof();
    tofIe = 1'b1;
    #1;
    chk("R10 irq low", 32'(irq), 0);
    clkSel = 2'b01; cntEn = 1'b1;
    step(3);
    tofClr = 1'b1;
    step(1);
    tofClr = 1'b0; cntEn = 1'b0;
    chk("R10 set wins", 32'(tof), 1);
    #1;
    chk("R10 irq high", 32'(irq), 1);
    tofIe = 1'b0;
    #1;
    chk("R10 irq masked", 32'(irq), 0);
    step(3);
    chk("R10 sticky", 32'(tof), 1);
    clrTof();
    chk("R10 cleared", 32'(tof), 0);

    finishRun();
  end
endmodule